// File: doc/BRIEF.md
# Conservative Issue Hazard Checker

This block sits beside the issue queue of a core that fetches in order, issues, executes and writes back out of order, and commits in order. It keeps one program-order slot per in-flight instruction. For each slot it holds the source and destination register numbers, whether the instruction writes a register, and whether it has issued and written back. Each cycle it grants issue to at most one waiting instruction: the oldest one that no older, still-tracked instruction blocks.

A read of a register that an older instruction produces is a true dependence. It is released as soon as the producer reports writeback. A write to a register that an older instruction also writes, or still reads, is a name dependence. It is held until that older instruction commits and leaves its slot. Register 0 is hardwired and never takes part in a dependence. Entries are added at the tail, and commit always removes the head. A flush empties the whole window.

Top module: `hzd_issue_check`

## Requirements
- R1: After reset, and in the cycle after `flush` is sampled high, no slot holds an instruction, `issue_gnt` is all zero and `full` is low. The next accepted instruction occupies slot 0.
- R2: A waiting instruction whose `src_a` or `src_b` equals the nonzero destination of an older writing instruction that has not written back is not granted. Once that producer's writeback is sampled, the instruction is granted in the following cycle if nothing else blocks it.
- R3: A waiting writing instruction whose nonzero destination equals the destination of an older writing instruction stays ungranted after that older instruction writes back. It is released only in the cycle after the older one commits.
- R4: A waiting writing instruction whose nonzero destination equals either source of an older instruction stays ungranted until that older instruction commits.
- R5: Register 0, used as a source or as a destination, never blocks any instruction.
- R6: `issue_gnt` is zero or one-hot. Bit i means slot i issues. When several slots are eligible, the bit goes to the one nearest the head in program order. Younger instructions never block older ones.
- R7: A granted instruction is marked issued at that clock edge and is never granted again.
- R8: `cmt_valid` removes the head instruction only if the head has written back. Otherwise the request is ignored, and the head keeps blocking younger instructions.
- R9: `full` is high while all slots are occupied. An enqueue requested while `full` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Synchronous clear of all slots |
| enq_valid | input | 1 | Add an instruction at the tail |
| enq_dst | input | REG_W | Destination register of the new instruction |
| enq_src_a | input | REG_W | First source register |
| enq_src_b | input | REG_W | Second source register |
| enq_wr | input | 1 | New instruction writes `enq_dst` |
| wb_valid | input | 1 | Writeback event |
| wb_slot | input | log2(NUM_SLOTS) | Slot that wrote back |
| cmt_valid | input | 1 | Commit request for the head slot |
| issue_gnt | output | NUM_SLOTS | One-hot issue grant per slot |
| full | output | 1 | All slots occupied |

## Verification
A commit and an issue grant can fall in the same cycle. That cycle also decides when a name-blocked instruction is released. The bench provokes this by committing the head while a younger, unrelated instruction is being granted. In the next cycle it expects the grant to go to the instruction that was waiting on the committed one, and not one cycle later. A commit requested in the same cycle as the head's own writeback is not used, because commit looks at the written-back state from before that edge.

// File: rtl/hzd_pkg.sv
package hzd_pkg;

   localparam int ARCH_REG_W = 5;

   typedef logic [ARCH_REG_W-1:0] areg_t;

   typedef struct packed {
      logic  vld;
      logic  iss;
      logic  wbd;
      logic  wr;
      areg_t dst;
      areg_t sa;
      areg_t sb;
   } slot_t;

endpackage

// File: rtl/hzd_slot_array.sv
module hzd_slot_array
   import hzd_pkg::*;
#(
   parameter int NUM_SLOTS = 8,
   localparam int IDX_W = $clog2(NUM_SLOTS),
   localparam int CNT_W = IDX_W + 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 flush,
   input  logic                 enq_valid,
   input  slot_t                enq_ent,
   input  logic                 wb_valid,
   input  logic [IDX_W-1:0]     wb_slot,
   input  logic                 cmt_valid,
   input  logic [NUM_SLOTS-1:0] gnt,
   output slot_t                slots [NUM_SLOTS],
   output logic [IDX_W-1:0]     head,
   output logic                 full
);

   localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(NUM_SLOTS);

   slot_t            q [NUM_SLOTS];
   logic [IDX_W-1:0] tail;
   logic [CNT_W-1:0] count;
   logic             do_enq;
   logic             do_cmt;

   assign full   = (count == CNT_MAX);
   assign do_enq = enq_valid && !full;
   assign do_cmt = cmt_valid && q[head].vld && q[head].wbd;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_SLOTS; i++) q[i] <= '0;
         head  <= '0;
         tail  <= '0;
         count <= '0;
      end else if (flush) begin
         for (int i = 0; i < NUM_SLOTS; i++) q[i].vld <= 1'b0;
         head  <= '0;
         tail  <= '0;
         count <= '0;
      end else begin
         for (int i = 0; i < NUM_SLOTS; i++) begin
            if (gnt[i]) q[i].iss <= 1'b1;
            if (wb_valid && (wb_slot == IDX_W'(i)) && q[i].vld && q[i].iss)
               q[i].wbd <= 1'b1;
         end
         if (do_cmt) begin
            q[head].vld <= 1'b0;
            head        <= head + 1'b1;
         end
         if (do_enq) begin
            q[tail]     <= enq_ent;
            q[tail].vld <= 1'b1;
            q[tail].iss <= 1'b0;
            q[tail].wbd <= 1'b0;
            tail        <= tail + 1'b1;
         end
         count <= count + CNT_W'(do_enq) - CNT_W'(do_cmt);
      end
   end

   always_comb begin
      for (int i = 0; i < NUM_SLOTS; i++) slots[i] = q[i];
   end

endmodule

// File: rtl/hzd_dep_matrix.sv
module hzd_dep_matrix
   import hzd_pkg::*;
#(
   parameter int NUM_SLOTS = 8,
   localparam int IDX_W = $clog2(NUM_SLOTS)
) (
   input  slot_t                slots [NUM_SLOTS],
   input  logic [IDX_W-1:0]     head,
   output logic [NUM_SLOTS-1:0] elig
);

   for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_cand
      logic [NUM_SLOTS-1:0] blk_row;
      logic [IDX_W-1:0]     age_i;
      logic                 dst_live;

      assign age_i    = IDX_W'(i) - head;
      assign dst_live = slots[i].wr && (slots[i].dst != '0);

      for (genvar j = 0; j < NUM_SLOTS; j++) begin : g_old
         logic [IDX_W-1:0] age_j;
         logic             older;
         logic             raw_hit;
         logic             waw_hit;
         logic             war_hit;

         assign age_j   = IDX_W'(j) - head;
         assign older   = (age_j < age_i) && slots[j].vld;
         assign raw_hit = slots[j].wr && (slots[j].dst != '0) && !slots[j].wbd &&
                          ((slots[i].sa == slots[j].dst) || (slots[i].sb == slots[j].dst));
         assign waw_hit = dst_live && slots[j].wr && (slots[j].dst == slots[i].dst);
         assign war_hit = dst_live &&
                          ((slots[j].sa == slots[i].dst) || (slots[j].sb == slots[i].dst));
         assign blk_row[j] = older && (raw_hit || waw_hit || war_hit);
      end

      assign elig[i] = slots[i].vld && !slots[i].iss && (blk_row == '0);
   end

endmodule

// File: rtl/hzd_age_pick.sv
module hzd_age_pick #(
   parameter int NUM_SLOTS = 8,
   localparam int IDX_W = $clog2(NUM_SLOTS)
) (
   input  logic [NUM_SLOTS-1:0] elig,
   input  logic [IDX_W-1:0]     head,
   output logic [NUM_SLOTS-1:0] gnt
);

   logic [IDX_W-1:0] idx;
   logic             found;

   always_comb begin
      gnt   = '0;
      found = 1'b0;
      idx   = '0;
      for (int k = 0; k < NUM_SLOTS; k++) begin
         idx = head + IDX_W'(k);
         if (!found && elig[idx]) begin
            gnt[idx] = 1'b1;
            found    = 1'b1;
         end
      end
   end

endmodule

// File: rtl/hzd_issue_check.sv
module hzd_issue_check
   import hzd_pkg::*;
#(
   parameter int NUM_SLOTS = 8,
   parameter int REG_W     = 5,
   localparam int IDX_W    = $clog2(NUM_SLOTS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 flush,
   input  logic                 enq_valid,
   input  logic [REG_W-1:0]     enq_dst,
   input  logic [REG_W-1:0]     enq_src_a,
   input  logic [REG_W-1:0]     enq_src_b,
   input  logic                 enq_wr,
   input  logic                 wb_valid,
   input  logic [IDX_W-1:0]     wb_slot,
   input  logic                 cmt_valid,
   output logic [NUM_SLOTS-1:0] issue_gnt,
   output logic                 full
);

   initial begin : g_param_chk
      assert (REG_W == ARCH_REG_W)
         else $error("REG_W must match the package register width");
      assert ((NUM_SLOTS >= 2) && ((NUM_SLOTS & (NUM_SLOTS - 1)) == 0))
         else $error("NUM_SLOTS must be a power of two of at least 2");
   end

   slot_t                new_ent;
   slot_t                slots [NUM_SLOTS];
   logic [IDX_W-1:0]     head;
   logic [NUM_SLOTS-1:0] elig;

   always_comb begin
      new_ent     = '0;
      new_ent.wr  = enq_wr;
      new_ent.dst = enq_dst;
      new_ent.sa  = enq_src_a;
      new_ent.sb  = enq_src_b;
   end

   hzd_slot_array #(.NUM_SLOTS(NUM_SLOTS)) u_slots (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (flush),
      .enq_valid (enq_valid),
      .enq_ent   (new_ent),
      .wb_valid  (wb_valid),
      .wb_slot   (wb_slot),
      .cmt_valid (cmt_valid),
      .gnt       (issue_gnt),
      .slots     (slots),
      .head      (head),
      .full      (full)
   );

   hzd_dep_matrix #(.NUM_SLOTS(NUM_SLOTS)) u_deps (
      .slots (slots),
      .head  (head),
      .elig  (elig)
   );

   hzd_age_pick #(.NUM_SLOTS(NUM_SLOTS)) u_pick (
      .elig (elig),
      .head (head),
      .gnt  (issue_gnt)
   );

endmodule

// File: rtl/hzd_issue_check_sva.sv
module hzd_issue_check_sva #(
   parameter int NUM_SLOTS = 8,
   parameter int REG_W     = 5,
   localparam int IDX_W    = $clog2(NUM_SLOTS)
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 flush,
   input logic                 enq_valid,
   input logic [REG_W-1:0]     enq_dst,
   input logic [REG_W-1:0]     enq_src_a,
   input logic [REG_W-1:0]     enq_src_b,
   input logic                 enq_wr,
   input logic                 wb_valid,
   input logic [IDX_W-1:0]     wb_slot,
   input logic                 cmt_valid,
   input logic [NUM_SLOTS-1:0] issue_gnt,
   input logic                 full
);

   AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(issue_gnt)); // R6

   AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (issue_gnt == '0) && !full); // R1

   AST_NO_REGRANT: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_gnt != '0) && !flush |=> ((issue_gnt & $past(issue_gnt)) == '0)); // R7

   AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      full && !cmt_valid && !flush |=> full); // R9

   AST_FULL_NEEDS_FILL: assert property (@(posedge clk) disable iff (!rst_n)
      !full && !enq_valid |=> !full); // R9

endmodule

bind hzd_issue_check hzd_issue_check_sva #(.NUM_SLOTS(NUM_SLOTS), .REG_W(REG_W)) u_sva (.*);

// File: tb/hzd_issue_check_test.sv
`timescale 1ns/1ps
module hzd_issue_check_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       flush = 1'b0;
   logic       enq_valid = 1'b0;
   logic [4:0] enq_dst = '0;
   logic [4:0] enq_src_a = '0;
   logic [4:0] enq_src_b = '0;
   logic       enq_wr = 1'b0;
   logic       wb_valid = 1'b0;
   logic [2:0] wb_slot = '0;
   logic       cmt_valid = 1'b0;
   logic [7:0] issue_gnt;
   logic       full;

   int checks = 0;
   int bad = 0;
   bit done = 1'b0;

   logic [7:0] q_gnt [$];
   logic       q_full [$];
   string      q_tag [$];

   always #10 clk = ~clk;

   hzd_issue_check uut (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .enq_valid(enq_valid), .enq_dst(enq_dst), .enq_src_a(enq_src_a),
      .enq_src_b(enq_src_b), .enq_wr(enq_wr),
      .wb_valid(wb_valid), .wb_slot(wb_slot), .cmt_valid(cmt_valid),
      .issue_gnt(issue_gnt), .full(full)
   );

   // monitor: compares the state seen before each active edge
   always @(negedge clk) begin
      #1;
      if (q_gnt.size() > 0) begin
         logic [7:0] eg;
         logic       ef;
         string      tg;
         eg = q_gnt.pop_front();
         ef = q_full.pop_front();
         tg = q_tag.pop_front();
         checks++;
         if (issue_gnt !== eg || full !== ef) begin
            bad++;
            $display("FAIL %s: gnt=%b full=%b expected gnt=%b full=%b",
                     tg, issue_gnt, full, eg, ef);
         end
      end
   end

   task automatic put(input logic [4:0] d, input logic [4:0] a,
                      input logic [4:0] b, input logic w);
      enq_valid = 1'b1; enq_dst = d; enq_src_a = a; enq_src_b = b; enq_wr = w;
   endtask

   task automatic wb(input logic [2:0] s);
      wb_valid = 1'b1; wb_slot = s;
   endtask

   task automatic cmt();
      cmt_valid = 1'b1;
   endtask

   // driver: push the expectation for this cycle, then cross one edge
   task automatic tick(input logic [7:0] eg, input logic ef, input string tg);
      q_gnt.push_back(eg);
      q_full.push_back(ef);
      q_tag.push_back(tg);
      @(posedge clk);
      @(negedge clk);
      enq_valid = 1'b0; wb_valid = 1'b0; cmt_valid = 1'b0; flush = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      tick(8'h00, 0, "R1 reset state");

      // R2 true dependence, head 0
      put(5'd1, 5'd2, 5'd3, 1); tick(8'h00, 0, "R2 setup");
      put(5'd4, 5'd1, 5'd0, 1); tick(8'h01, 0, "R2 producer granted");
      wb(3'd0);                 tick(8'h00, 0, "R2 consumer blocked");
      tick(8'h02, 0, "R2 consumer released after writeback");
      wb(3'd1); cmt();          tick(8'h00, 0, "R7 no second grant");
      cmt();                    tick(8'h00, 0, "R2 drain");

      // R3 write after write, head 2
      put(5'd5, 5'd0, 5'd0, 1); tick(8'h00, 0, "R3 setup");
      put(5'd5, 5'd6, 5'd7, 1); tick(8'h04, 0, "R3 first writer granted");
      wb(3'd2);                 tick(8'h00, 0, "R3 second writer blocked");
      cmt();                    tick(8'h00, 0, "R3 blocked after writeback");
      tick(8'h08, 0, "R3 released after commit");
      wb(3'd3);                 tick(8'h00, 0, "R3 drain");
      cmt();                    tick(8'h00, 0, "R3 drain");

      // R4 write after read, head 4
      put(5'd9, 5'd0, 5'd0, 1);   tick(8'h00, 0, "R4 setup");
      put(5'd10, 5'd9, 5'd12, 1); tick(8'h10, 0, "R4 producer granted");
      put(5'd12, 5'd0, 5'd0, 1);  tick(8'h00, 0, "R2 reader blocked");
      wb(3'd4);                   tick(8'h00, 0, "R4 writer blocked by reader");
      tick(8'h20, 0, "R2 reader released");
      wb(3'd5); cmt();            tick(8'h00, 0, "R4 blocked while reader uncommitted");
      cmt();                      tick(8'h00, 0, "R4 blocked after reader writeback");
      tick(8'h40, 0, "R4 released after reader commit");
      wb(3'd6);                   tick(8'h00, 0, "R4 drain");
      cmt();                      tick(8'h00, 0, "R4 drain");

      // R5 register zero, head 7
      put(5'd0, 5'd0, 5'd0, 1); tick(8'h00, 0, "R5 setup");
      put(5'd0, 5'd0, 5'd0, 1); tick(8'h80, 0, "R5 first granted");
      tick(8'h01, 0, "R5 register zero creates no dependence");
      wb(3'd7);                 tick(8'h00, 0, "R5 drain");
      wb(3'd0); cmt();          tick(8'h00, 0, "R5 drain");
      cmt();                    tick(8'h00, 0, "R5 drain");

      // R6 oldest first, younger never blocks older, head 1
      put(5'd13, 5'd0, 5'd0, 1);  tick(8'h00, 0, "R6 setup");
      put(5'd7, 5'd13, 5'd0, 1);  tick(8'h02, 0, "R6 producer granted");
      put(5'd7, 5'd0, 5'd0, 1);   tick(8'h00, 0, "R6 setup");
      put(5'd16, 5'd13, 5'd0, 1); tick(8'h00, 0, "R2 two readers blocked");
      wb(3'd1);                   tick(8'h00, 0, "R2 readers blocked");
      tick(8'h04, 0, "R6 oldest eligible wins");
      wb(3'd2); cmt();            tick(8'h10, 0, "R6 next eligible granted with commit");
      cmt();                      tick(8'h00, 0, "R3 waits for older writer commit");
      wb(3'd4);                   tick(8'h08, 0, "R3 released in cycle after commit");
      wb(3'd3);                   tick(8'h00, 0, "R6 drain");
      cmt();                      tick(8'h00, 0, "R6 drain");
      cmt();                      tick(8'h00, 0, "R6 drain");

      // R8 commit before writeback is ignored, head 5
      put(5'd20, 5'd0, 5'd0, 1); tick(8'h00, 0, "R8 setup");
      put(5'd20, 5'd0, 5'd0, 1); tick(8'h20, 0, "R8 head granted");
      cmt();                     tick(8'h00, 0, "R8 early commit request");
      wb(3'd5);                  tick(8'h00, 0, "R8 head still blocks after early commit");
      cmt();                     tick(8'h00, 0, "R8 head written back not committed");
      tick(8'h40, 0, "R8 released after real commit");
      wb(3'd6);                  tick(8'h00, 0, "R8 drain");
      cmt();                     tick(8'h00, 0, "R8 drain");

      // R9 full window, head 7
      for (int k = 0; k < 8; k++) begin
         put(5'd21, 5'd0, 5'd0, 1);
         tick((k == 1) ? 8'h80 : 8'h00, 0, "R9 fill");
      end
      put(5'd22, 5'd0, 5'd0, 1); tick(8'h00, 1, "R9 full asserted");
      wb(3'd7);                  tick(8'h00, 1, "R9 enqueue while full ignored");
      cmt();                     tick(8'h00, 1, "R9 still full");
      tick(8'h01, 0, "R9 one slot freed by commit");

      // R1 flush
      flush = 1'b1;              tick(8'h00, 0, "R1 before flush");
      tick(8'h00, 0, "R1 empty after flush");
      put(5'd1, 5'd0, 5'd0, 1);  tick(8'h00, 0, "R1 enqueue after flush");
      tick(8'h01, 0, "R1 first entry lands in slot 0");

      @(negedge clk);
      #3;
      if (!done) begin
         done = 1'b1;
         $display("test done: total=%0d bad=%0d", checks, bad);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         bad++;
         $display("FAIL watchdog: run did not finish, actual=hung expected=done");
         $display("test done: total=%0d bad=%0d", checks, bad);
         $finish;
      end
   end

endmodule